// File: doc/BRIEF.md
# Hot-Plug Slot Sequencer

This block runs one hot-pluggable expansion slot for system software. It watches a card retention latch sensor, a card-presence detect and an operator attention button. It takes one-cycle software commands to power the slot up, power it down, or set the attention indicator. It drives slot power, the card reset, an electromechanical interlock, a power indicator that can be off, steady or blinking, and a separate attention indicator. Button presses, latch closures and rejected commands are held as sticky event bits. The interrupt line is the OR of the event bits that are enabled.

A button press on an empty, unpowered slot starts a hot-add request. A press on a live slot starts a hot-remove request. Each request opens a timed window with the power indicator blinking, and a cancel during that window puts the slot back where it was. Once the window has expired, the slot waits for software. For an add, software sends a power-on command. For a remove, software quiesces the driver and then sends a power-off command. Power-up holds the card in reset until a ramp delay has elapsed. Power-down asserts reset, waits a drain delay, removes power, and only then turns the indicator off.

Top module: `slot_hp_ctrl`

## Requirements
- R1: A rising edge on latch_closed_i sets event bit 0 one clock edge later, while a falling edge sets nothing. status_o carries {card_present_i, latch_closed_i} registered by one edge.
- R2: A rising edge on button_i in the unpowered idle state sets event bit 1 and starts a hot-add window. pwr_ind_o reads 2 (blink) from the same edge, and power stays off.
- R3: A request window spans the WIN_CYCLES edges that follow the request edge. cancel_i sampled on any of those edges returns the slot to its state before the request. cancel_i sampled later, or in any other state, has no effect.
- R4: A power-on command (cmd_op_i = 1 with cmd_valid_i), issued from idle or after an expired add window while the latch is closed and a card is present, raises power_en_o with card_reset_o held high for RAMP_CYCLES edges. After that, reset falls and pwr_ind_o reads 1 (steady on).
- R5: A power-on command given while the latch is open or no card is present sets event bit 2 and leaves power off.
- R6: interlock_o is high on exactly those cycles where power_en_o is high.
- R7: A power-off command (cmd_op_i = 2) from the live state or after an expired remove window asserts card_reset_o at once. Power stays on for DRAIN_CYCLES edges, then power_en_o and interlock_o fall and pwr_ind_o reads 0.
- R8: A rising edge on button_i in the live state starts a remove window with pwr_ind_o = 2 and power and reset unchanged. Power is never removed without a power-off command.
- R9: cmd_op_i = 3 copies cmd_attn_i to attn_led_o one edge later and leaves the power indicator unchanged.
- R10: Event bits are sticky and cleared by writing 1 to evt_clr_i, and a new event on the same edge wins over the clear. irq_o is the OR of (events AND evt_en_i), updated on the same edge as the events.
- R11: pwr_led_o is 0 when the indicator is off and 1 when it is on. While blinking, it is high on exactly BLINK_DIV of any 2*BLINK_DIV consecutive cycles.
- R12: During reset, power, interlock, both indicators, events and irq are 0, and card_reset_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_closed_i | input | 1 | Retention latch sensor, 1 = closed |
| card_present_i | input | 1 | Card presence detect |
| button_i | input | 1 | Attention button level |
| cancel_i | input | 1 | Cancel of an open request window |
| cmd_valid_i | input | 1 | Software command strobe |
| cmd_op_i | input | 2 | 1 power on, 2 power off, 3 attention indicator |
| cmd_attn_i | input | 1 | Attention indicator value for op 3 |
| evt_clr_i | input | 3 | Write-1-to-clear pulse per event bit |
| evt_en_i | input | 3 | Interrupt enable per event bit |
| power_en_o | output | 1 | Slot power enable |
| card_reset_o | output | 1 | Card reset, active high |
| interlock_o | output | 1 | Electromechanical interlock engaged |
| pwr_ind_o | output | 2 | Power indicator mode: 0 off, 1 on, 2 blink |
| pwr_led_o | output | 1 | Power indicator drive level |
| attn_led_o | output | 1 | Attention indicator drive |
| status_o | output | 2 | {card present, latch closed} |
| events_o | output | 3 | Bit 0 latch closed, bit 1 button, bit 2 rejected power-on |
| irq_o | output | 1 | Interrupt request |

## Verification
All outputs are registered from the next-state decode, so every result is due on the first clock edge after the stimulus edge. The bench therefore changes inputs just after a falling edge and reads outputs at the next falling edge. Timed windows are walked edge by edge. Reset is checked to hold for exactly RAMP_CYCLES edges and power for exactly DRAIN_CYCLES edges. A cancel is applied on the last edge inside the window and again on the first edge after it, so each window is checked from both sides. Blinking is judged by counting high samples over a full period rather than by phase, so the result does not depend on when the divider started.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;
  localparam int EVT_W     = 3;
  localparam int EV_LATCH  = 0;
  localparam int EV_BUTTON = 1;
  localparam int EV_REJECT = 2;

  typedef enum logic [1:0] {
    OP_NOP     = 2'd0,
    OP_PWR_ON  = 2'd1,
    OP_PWR_OFF = 2'd2,
    OP_ATTN    = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    IND_OFF   = 2'd0,
    IND_ON    = 2'd1,
    IND_BLINK = 2'd2
  } ind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADD_WIN, ST_ADD_HOLD, ST_RAMP,
    ST_LIVE, ST_REM_WIN, ST_REM_HOLD, ST_DRAIN
  } slot_st_e;
endpackage

// File: rtl/slot_hp_timer.sv
module slot_hp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/slot_hp_blink.sv
module slot_hp_blink #(
  parameter int BLINK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic phase_o
);
  localparam int DW = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(BLINK_DIV - 1);

  logic [DW-1:0] div_q;
  logic          phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (div_q == LAST) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      div_q   <= div_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/slot_hp_events.sv
module slot_hp_events #(
  parameter int EVT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] set_i,
  input  logic [EVT_W-1:0] clr_i,
  input  logic [EVT_W-1:0] en_i,
  output logic [EVT_W-1:0] evt_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] evt_q, evt_d;
  logic             irq_q;

  assign evt_d = (evt_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      irq_q <= |(evt_d & en_i);
    end
  end

  assign evt_o = evt_q;
  assign irq_o = irq_q;

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((($past(evt_q) & ~$past(clr_i)) & ~evt_q) == '0)); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (evt_q != '0)); // R10
endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
  import slot_hp_pkg::*;
#(
  parameter int WIN_CYCLES   = 1_000_000_000,
  parameter int RAMP_CYCLES  = 20_000_000,
  parameter int DRAIN_CYCLES = 200_000,
  parameter int BLINK_DIV    = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       latch_closed_i,
  input  logic       card_present_i,
  input  logic       button_i,
  input  logic       cancel_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic       cmd_attn_i,
  input  logic [2:0] evt_clr_i,
  input  logic [2:0] evt_en_i,
  output logic       power_en_o,
  output logic       card_reset_o,
  output logic       interlock_o,
  output logic [1:0] pwr_ind_o,
  output logic       pwr_led_o,
  output logic       attn_led_o,
  output logic [1:0] status_o,
  output logic [2:0] events_o,
  output logic       irq_o
);
  localparam int MAX_A   = (WIN_CYCLES > RAMP_CYCLES) ? WIN_CYCLES : RAMP_CYCLES;
  localparam int MAX_LEN = (MAX_A > DRAIN_CYCLES) ? MAX_A : DRAIN_CYCLES;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] WIN_LEN   = CNT_W'(WIN_CYCLES);
  localparam logic [CNT_W-1:0] RAMP_LEN  = CNT_W'(RAMP_CYCLES);
  localparam logic [CNT_W-1:0] DRAIN_LEN = CNT_W'(DRAIN_CYCLES);

  slot_st_e         st_q, st_d;
  logic             btn_q, btn_rise, latch_rise;
  logic             cmd_on, cmd_off, cmd_attn, slot_ready, reject;
  logic             tmr_load, tmr_done, blink_phase;
  logic [CNT_W-1:0] tmr_len;
  logic             pwr_d, rst_d;
  ind_e             mode_d;
  logic [EVT_W-1:0] evt_set;

  assign cmd_on     = cmd_valid_i && (cmd_op_i == OP_PWR_ON);
  assign cmd_off    = cmd_valid_i && (cmd_op_i == OP_PWR_OFF);
  assign cmd_attn   = cmd_valid_i && (cmd_op_i == OP_ATTN);
  assign slot_ready = latch_closed_i && card_present_i;
  assign btn_rise   = button_i && !btn_q;
  assign latch_rise = latch_closed_i && !status_o[0];

  // Sequencing state machine
  always_comb begin
    st_d   = st_q;
    reject = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_ADD_HOLD: begin
        if (cmd_on) begin
          if (slot_ready) st_d = ST_RAMP;
          else            reject = 1'b1;
        end else if (st_q == ST_IDLE && btn_rise) begin
          st_d = ST_ADD_WIN;
        end
      end
      ST_ADD_WIN:  if (cancel_i) st_d = ST_IDLE;
                   else if (tmr_done) st_d = ST_ADD_HOLD;
      ST_RAMP:     if (tmr_done) st_d = ST_LIVE;
      ST_LIVE:     if (cmd_off) st_d = ST_DRAIN;
                   else if (btn_rise) st_d = ST_REM_WIN;
      ST_REM_WIN:  if (cancel_i) st_d = ST_LIVE;
                   else if (tmr_done) st_d = ST_REM_HOLD;
      ST_REM_HOLD: if (cmd_off) st_d = ST_DRAIN;
      ST_DRAIN:    if (tmr_done) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  // Timer length for the state being entered
  assign tmr_load = (st_d != st_q);
  always_comb begin
    unique case (st_d)
      ST_ADD_WIN, ST_REM_WIN: tmr_len = WIN_LEN;
      ST_RAMP:                tmr_len = RAMP_LEN;
      ST_DRAIN:               tmr_len = DRAIN_LEN;
      default:                tmr_len = CNT_W'(1);
    endcase
  end

  // Output decode from the next state
  always_comb begin
    pwr_d  = 1'b0;
    rst_d  = 1'b1;
    mode_d = IND_OFF;
    unique case (st_d)
      ST_IDLE:                 ;
      ST_ADD_WIN, ST_ADD_HOLD: mode_d = IND_BLINK;
      ST_RAMP:                 begin pwr_d = 1'b1; mode_d = IND_BLINK; end
      ST_LIVE:                 begin pwr_d = 1'b1; rst_d = 1'b0; mode_d = IND_ON; end
      ST_REM_WIN, ST_REM_HOLD: begin pwr_d = 1'b1; rst_d = 1'b0; mode_d = IND_BLINK; end
      ST_DRAIN:                begin pwr_d = 1'b1; mode_d = IND_BLINK; end
      default:                 ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      btn_q        <= 1'b0;
      status_o     <= 2'b00;
      power_en_o   <= 1'b0;
      interlock_o  <= 1'b0;
      card_reset_o <= 1'b1;
      pwr_ind_o    <= IND_OFF;
      pwr_led_o    <= 1'b0;
      attn_led_o   <= 1'b0;
    end else begin
      st_q         <= st_d;
      btn_q        <= button_i;
      status_o     <= {card_present_i, latch_closed_i};
      power_en_o   <= pwr_d;
      interlock_o  <= pwr_d;
      card_reset_o <= rst_d;
      pwr_ind_o    <= mode_d;
      pwr_led_o    <= (mode_d == IND_ON) || ((mode_d == IND_BLINK) && blink_phase);
      if (cmd_attn) attn_led_o <= cmd_attn_i;
    end
  end

  always_comb begin
    evt_set            = '0;
    evt_set[EV_LATCH]  = latch_rise;
    evt_set[EV_BUTTON] = btn_rise;
    evt_set[EV_REJECT] = reject;
  end

  slot_hp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load_i(tmr_load), .len_i(tmr_len), .done_o(tmr_done)
  );

  slot_hp_blink #(.BLINK_DIV(BLINK_DIV)) u_blink (
    .clk(clk), .rst(rst), .phase_o(blink_phase)
  );

  slot_hp_events #(.EVT_W(EVT_W)) u_events (
    .clk(clk), .rst(rst), .set_i(evt_set), .clr_i(evt_clr_i),
    .en_i(evt_en_i), .evt_o(events_o), .irq_o(irq_o)
  );

  AST_RAMP_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(power_en_o) |-> card_reset_o); // R4
  AST_OFF_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !power_en_o |-> card_reset_o); // R4
  AST_DRAIN_ORDER: assert property (@(posedge clk) disable iff (rst)
    $fell(power_en_o) |-> ($past(card_reset_o) && pwr_ind_o == IND_OFF)); // R7
  AST_REJECT_NOPWR: assert property (@(posedge clk) disable iff (rst)
    (cmd_on && !slot_ready && !power_en_o) |=> !power_en_o); // R5
  AST_LOCK_LIVE: assert property (@(posedge clk) disable iff (rst)
    $fell(interlock_o) |-> !power_en_o); // R6
endmodule

// File: tb/slot_hp_ctrl_test.sv
`timescale 1ns/1ps
module slot_hp_ctrl_test;
  localparam int WIN   = 4;
  localparam int RAMP  = 3;
  localparam int DRAIN = 2;
  localparam int DIV   = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       latch = 1'b0, present = 1'b0, button = 1'b0, cancel = 1'b0;
  logic       cmd_valid = 1'b0, cmd_attn = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [2:0] clr = 3'b000, en = 3'b000;
  logic       power_en, card_reset, interlock, pwr_led, attn_led, irq;
  logic [1:0] pwr_ind, status;
  logic [2:0] events;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  slot_hp_ctrl #(.WIN_CYCLES(WIN), .RAMP_CYCLES(RAMP), .DRAIN_CYCLES(DRAIN),
                 .BLINK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .latch_closed_i(latch), .card_present_i(present),
    .button_i(button), .cancel_i(cancel), .cmd_valid_i(cmd_valid),
    .cmd_op_i(cmd_op), .cmd_attn_i(cmd_attn), .evt_clr_i(clr), .evt_en_i(en),
    .power_en_o(power_en), .card_reset_o(card_reset), .interlock_o(interlock),
    .pwr_ind_o(pwr_ind), .pwr_led_o(pwr_led), .attn_led_o(attn_led),
    .status_o(status), .events_o(events), .irq_o(irq)
  );

  typedef struct packed {
    logic       latch;
    logic       present;
    logic       cmd_on;
    logic [2:0] clr;
    logic [2:0] en;
    logic [2:0] exp_evt;
    logic       exp_irq;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b0, 1'b0, 3'b000, 3'b111, 3'b001, 1'b1},
    '{1'b1, 1'b0, 1'b0, 3'b001, 3'b111, 3'b000, 1'b0},
    '{1'b0, 1'b0, 1'b0, 3'b000, 3'b111, 3'b000, 1'b0},
    '{1'b0, 1'b0, 1'b1, 3'b000, 3'b111, 3'b100, 1'b1},
    '{1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 3'b100, 1'b0},
    '{1'b1, 1'b0, 1'b0, 3'b000, 3'b100, 3'b101, 1'b1},
    '{1'b1, 1'b0, 1'b0, 3'b100, 3'b100, 3'b001, 1'b0},
    '{1'b1, 1'b0, 1'b1, 3'b001, 3'b001, 3'b100, 1'b0},
    '{1'b0, 1'b1, 1'b1, 3'b100, 3'b100, 3'b100, 1'b1},
    '{1'b0, 1'b0, 1'b0, 3'b111, 3'b111, 3'b000, 1'b0}
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send(logic [1:0] op, logic a);
    cmd_valid = 1'b1; cmd_op = op; cmd_attn = a;
    step();
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  task automatic press();
    button = 1'b1;
    step();
    button = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    int highs;
    repeat (3) step();
    // R12 reset state
    chk("R12", "power", power_en, 0);
    chk("R12", "reset", card_reset, 1);
    chk("R12", "lock", interlock, 0);
    chk("R12", "ind", pwr_ind, 0);
    chk("R12", "led", pwr_led, 0);
    chk("R12", "attn", attn_led, 0);
    chk("R12", "events", events, 0);
    chk("R12", "irq", irq, 0);
    rst = 1'b0;
    step();

    // Event, clear, enable and rejection table: R10 R1 R5
    foreach (VECS[i]) begin
      latch = VECS[i].latch; present = VECS[i].present;
      clr = VECS[i].clr; en = VECS[i].en;
      cmd_valid = VECS[i].cmd_on; cmd_op = VECS[i].cmd_on ? 2'd1 : 2'd0;
      step();
      chk("R10", $sformatf("row%0d events", i), events, VECS[i].exp_evt);
      chk("R10", $sformatf("row%0d irq", i), irq, VECS[i].exp_irq);
      chk("R5", $sformatf("row%0d power", i), power_en, 0);
    end
    cmd_valid = 1'b0; cmd_op = 2'd0; clr = 3'b000;

    // R1 latch closing and status
    en = 3'b111; latch = 1'b1; present = 1'b1;
    step();
    chk("R1", "latch event", events, 3'b001);
    chk("R1", "status", status, 2'b11);
    chk("R10", "irq", irq, 1);
    clr = 3'b001; step(); clr = 3'b000;

    // R2 hot-add request, R3 cancel on last window edge
    press();
    chk("R2", "ind blink", pwr_ind, 2);
    chk("R2", "button event", events[1], 1);
    chk("R2", "power", power_en, 0);
    clr = 3'b010;
    repeat (WIN - 1) step();
    clr = 3'b000;
    cancel = 1'b1; step(); cancel = 1'b0;
    chk("R3", "cancel in window", pwr_ind, 0);

    // R3 cancel one edge after the window is ignored
    press();
    repeat (WIN) step();
    cancel = 1'b1; step(); cancel = 1'b0;
    chk("R3", "late cancel ind", pwr_ind, 2);
    chk("R3", "late cancel power", power_en, 0);

    // R4 power-up from hold
    send(2'd1, 1'b0);
    chk("R4", "power", power_en, 1);
    chk("R4", "reset ramp", card_reset, 1);
    chk("R6", "lock", interlock, 1);
    repeat (RAMP - 1) step();
    chk("R4", "reset last ramp", card_reset, 1);
    step();
    chk("R4", "reset released", card_reset, 0);
    chk("R4", "ind on", pwr_ind, 1);
    chk("R11", "led steady", pwr_led, 1);

    // R3 cancel outside a window
    cancel = 1'b1; step(); cancel = 1'b0;
    chk("R3", "cancel live ind", pwr_ind, 1);
    chk("R3", "cancel live power", power_en, 1);

    // R9 attention indicator
    send(2'd3, 1'b1);
    chk("R9", "attn on", attn_led, 1);
    chk("R9", "ind kept", pwr_ind, 1);

    // R8 remove request and cancel
    press();
    chk("R8", "ind blink", pwr_ind, 2);
    chk("R8", "power", power_en, 1);
    chk("R8", "reset", card_reset, 0);
    cancel = 1'b1; step(); cancel = 1'b0;
    chk("R8", "cancel back live", pwr_ind, 1);

    // R8 expired remove window keeps power; R11 blink duty
    press();
    repeat (WIN) step();
    highs = 0;
    for (int k = 0; k < 2 * DIV; k++) begin
      step();
      if (pwr_led) highs++;
    end
    chk("R11", "blink highs", highs, DIV);
    chk("R8", "power held", power_en, 1);
    chk("R8", "ind", pwr_ind, 2);

    // R7 power-down ordering
    send(2'd2, 1'b0);
    chk("R7", "reset first", card_reset, 1);
    chk("R7", "power kept", power_en, 1);
    repeat (DRAIN - 1) step();
    chk("R7", "power last drain", power_en, 1);
    chk("R6", "lock drain", interlock, 1);
    step();
    chk("R7", "power off", power_en, 0);
    chk("R6", "lock off", interlock, 0);
    chk("R7", "ind off", pwr_ind, 0);
    chk("R11", "led off", pwr_led, 0);

    // R5 rejection with no card
    present = 1'b0; clr = 3'b111; step(); clr = 3'b000;
    send(2'd1, 1'b0);
    chk("R5", "no card power", power_en, 0);
    chk("R5", "reject event", events, 3'b100);

    // R4 direct power-on from idle, R9 clear attention
    present = 1'b1;
    send(2'd1, 1'b0);
    chk("R4", "direct power", power_en, 1);
    repeat (RAMP) step();
    chk("R4", "direct live", card_reset, 0);
    send(2'd3, 1'b0);
    chk("R9", "attn off", attn_led, 0);
    chk("R9", "ind kept 2", pwr_ind, 1);

    report();
  end
endmodule